// File: doc/BRIEF.md
# Randomized Bus Retry Backoff

This block sits on the master side of a shared bus. It takes one request at a time and drives it onto the bus. When the target answers with a retry response, the block drops its request-valid signal. It then waits a pseudo-random number of cycles, from 1 to 32, and offers the same request again. Each contending master that carries one of these controllers draws its own delay. This keeps two masters from retrying in lockstep and colliding again and again. A 16-bit linear feedback shift register supplies the delays, and each master can be given its own seed so that their sequences differ.

The captured address, write data and byte-enable lanes stay on the outputs without change from the moment the request is taken until the next request is accepted. The byte enables in particular are never dropped during a wait. A parameterized limit caps the number of retries. When one more retry response arrives after the limit is reached, the request is abandoned and an error pulse is raised.

Top module: `retry_backoff_ctrl`

## Requirements
- R1: After reset, `req_o`, `busy_o`, `wait_o` and `err_o` are low and `wait_cnt_o` is zero.
- R2: `issue_i` while idle captures `addr_i`, `data_i` and `sel_i`, and the next cycle shows `req_o` and `busy_o` high with the captured values on the outputs. `issue_i` while busy is ignored: the outputs keep the earlier values.
- R3: A retry response while `req_o` is high, with `ack_i` low and the limit not yet reached, gives on the next cycle `req_o` low, `wait_o` high, and `wait_cnt_o` equal to the generator's low 5 bits plus one, which lies in 1..32.
- R4: While waiting, `wait_cnt_o` falls by one each cycle. `req_o` stays low for exactly the drawn number of cycles, and it rises in the cycle in which `wait_cnt_o` reaches zero.
- R5: `addr_o`, `data_o` and `sel_o` do not change during a wait or on the reissue.
- R6: The generator is a 16-bit Galois shift register. Each step shifts the state right by one and XORs in 16'hB400 when the bit shifted out is 1. It loads `LFSR_SEED` in reset, steps every cycle, and the draw uses the state present at the clock edge that accepts the retry.
- R7: A retry response to a reissued request makes a fresh draw from the generator's current state. It does not reuse the earlier wait.
- R8: `ack_i` while `req_o` is high ends the transaction, so the next cycle shows `req_o` and `busy_o` low. When `ack_i` and `retry_i` arrive in the same cycle, the acknowledge wins and no wait starts.
- R9: After `MAX_RETRY` waits in one transaction, the next retry response raises `err_o` for exactly one cycle. In that same cycle the block is idle, with no wait started.
- R10: `ack_i` and `retry_i` are ignored while idle or waiting: they change neither `busy_o`, `wait_o`, nor the length of a wait in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Offer a new request (taken only when idle) |
| addr_i | input | ADDR_W | Request address |
| data_i | input | DATA_W | Request write data |
| sel_i | input | SEL_W | Request byte enables |
| ack_i | input | 1 | Target completed the request |
| retry_i | input | 1 | Target asks for the request to be retried |
| req_o | output | 1 | Request valid on the bus |
| addr_o | output | ADDR_W | Held request address |
| data_o | output | DATA_W | Held write data |
| sel_o | output | SEL_W | Held byte enables |
| busy_o | output | 1 | A transaction is in progress |
| wait_o | output | 1 | Backoff wait in progress |
| wait_cnt_o | output | 6 | Cycles left in the current wait |
| err_o | output | 1 | One-cycle pulse: transaction abandoned at the retry limit |

## Verification
An acknowledge and a retry response can land in the same cycle while the request is valid. The bench provokes this by raising both inputs for one cycle on an active request. It then expects the transaction to end with no wait started and nothing queued in the scoreboard. The same pair of inputs is also raised together in the middle of a backoff wait. There the bench expects the block to stay busy and waiting, and the monitor confirms that the wait still lasts exactly the drawn length.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

  localparam int LFSR_W    = 16;
  localparam int WAIT_BITS = 5;
  localparam int CNT_W     = WAIT_BITS + 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_WAIT   = 2'd2
  } xfer_state_e;

  // Galois step: shift right, fold the feedback mask in when a one leaves.
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s,
                                                  input logic [LFSR_W-1:0] taps);
    return (s >> 1) ^ (s[0] ? taps : '0);
  endfunction

  // Backoff length from a generator state: low bits plus one, range 1..2**WAIT_BITS.
  function automatic logic [CNT_W-1:0] draw_wait(input logic [LFSR_W-1:0] s);
    return {1'b0, s[WAIT_BITS-1:0]} + CNT_W'(1);
  endfunction

endpackage

// File: rtl/backoff_lfsr.sv
module backoff_lfsr
  import backoff_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] state_o
);

  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= lfsr_next(state_q, TAPS);
  end

  assign state_o = state_q;

  // A maximal-length register must never fall into the all-zero lock state.
  assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/backoff_timer.sv
module backoff_timer
  import backoff_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o    = cnt_q;
  assign expire_o = (cnt_q == CNT_W'(1));

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/req_hold.sv
module req_hold #(
  parameter int WIDTH = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         q_q <= '0;
    else if (capture_i) q_q <= d_i;
  end

  assign q_o = q_q;

  assert_held_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(q_q));

endmodule

// File: rtl/retry_backoff_ctrl.sv
module retry_backoff_ctrl
  import backoff_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                SEL_W     = DATA_W / 8,
  parameter int                MAX_RETRY = 3,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              ack_i,
  input  logic              retry_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              busy_o,
  output logic              wait_o,
  output logic [CNT_W-1:0]  wait_cnt_o,
  output logic              err_o
);

  localparam int HOLD_W = ADDR_W + DATA_W + SEL_W;
  localparam int RC_W   = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
  localparam logic [CNT_W-1:0] WAIT_MAX = CNT_W'(1 << WAIT_BITS);

  xfer_state_e       state_q, state_d;
  logic [RC_W-1:0]   retries_q;
  logic              err_q;
  logic [LFSR_W-1:0] rnd;
  logic              tmr_expire;
  logic [CNT_W-1:0]  tmr_cnt;

  // Named internal events
  logic accept, ack_take, retry_seen, give_up, retry_take;

  assign accept     = (state_q == ST_IDLE) && issue_i;
  assign ack_take   = (state_q == ST_ACTIVE) && ack_i;
  assign retry_seen = (state_q == ST_ACTIVE) && retry_i && !ack_i;
  assign give_up    = retry_seen && (retries_q == RC_W'(MAX_RETRY));
  assign retry_take = retry_seen && !give_up;

  backoff_lfsr #(.SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_o (rnd)
  );

  backoff_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (retry_take),
    .load_val_i (draw_wait(rnd)),
    .cnt_o      (tmr_cnt),
    .expire_o   (tmr_expire)
  );

  logic [HOLD_W-1:0] hold_q;

  req_hold #(.WIDTH(HOLD_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (accept),
    .d_i       ({addr_i, data_i, sel_i}),
    .q_o       (hold_q)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_ACTIVE;
      ST_ACTIVE: begin
        if (ack_take || give_up) state_d = ST_IDLE;
        else if (retry_take)     state_d = ST_WAIT;
      end
      ST_WAIT:   if (tmr_expire) state_d = ST_ACTIVE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      retries_q <= '0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= give_up;
      if (accept)          retries_q <= '0;
      else if (retry_take) retries_q <= retries_q + RC_W'(1);
    end
  end

  assign req_o      = (state_q == ST_ACTIVE);
  assign busy_o     = (state_q != ST_IDLE);
  assign wait_o     = (state_q == ST_WAIT);
  assign wait_cnt_o = tmr_cnt;
  assign err_o      = err_q;
  assign {addr_o, data_o, sel_o} = hold_q;

  assert_draw_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    retry_take |=> (wait_o && !req_o && wait_cnt_o >= CNT_W'(1) && wait_cnt_o <= WAIT_MAX));

  assert_reissue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && tmr_expire) |=> (req_o && wait_cnt_o == '0));

  assert_ack_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> (!busy_o && !err_o));

  assert_give_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |=> (err_o && !busy_o && !wait_o));

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  assert_idle_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !issue_i) |=> !busy_o);

  assert_wait_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && !tmr_expire) |=> wait_o);

endmodule

// File: tb/retry_backoff_ctrl_tb_top.sv
`timescale 1ns/1ps
module retry_backoff_ctrl_tb_top;

  localparam int          AW   = 32;
  localparam int          DW   = 32;
  localparam int          SW   = 4;
  localparam int          MAXR = 3;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [15:0] POLY = 16'hB400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_i = 1'b0, ack_i = 1'b0, retry_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [SW-1:0] sel_i = '0;
  logic          req_o, busy_o, wait_o, err_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o;
  logic [SW-1:0] sel_o;
  logic [5:0]    wait_cnt_o;

  always #4 clk = ~clk;

  retry_backoff_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .SEL_W(SW), .MAX_RETRY(MAXR),
    .LFSR_SEED(SEED), .LFSR_TAPS(POLY)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .addr_i(addr_i), .data_i(data_i),
    .sel_i(sel_i), .ack_i(ack_i), .retry_i(retry_i), .req_o(req_o), .addr_o(addr_o),
    .data_o(data_o), .sel_o(sel_o), .busy_o(busy_o), .wait_o(wait_o),
    .wait_cnt_o(wait_cnt_o), .err_o(err_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int exp_q[$];

  // Independent generator model (R6): right shift, mask folded in on a one out.
  logic [15:0] model;
  always @(posedge clk) begin
    if (!rst_n) model <= SEED;
    else        model <= model[0] ? ((model >> 1) ^ POLY) : (model >> 1);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Scoreboard monitor: pops the expected draw at each wait start and follows the wait.
  initial begin
    bit prev_w = 1'b0;
    int cur = 0, left = 0, len = 0;
    logic [AW+DW+SW-1:0] held = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_w = 1'b0;
      end else begin
        if (wait_o && !prev_w) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected wait start", wait_cnt_o, 0);
            cur = 0;
          end else begin
            cur = exp_q.pop_front();
            chk(wait_cnt_o == cur, "R3 R6 drawn wait", wait_cnt_o, cur);
          end
          left = wait_cnt_o;
          len  = 0;
          held = {addr_o, data_o, sel_o};
        end
        if (wait_o) begin
          chk(wait_cnt_o == left, "R4 count down", wait_cnt_o, left);
          chk(!req_o && ({addr_o, data_o, sel_o} == held), "R5 held during wait",
              {req_o, sel_o}, {1'b0, held[SW-1:0]});
          left--;
          len++;
        end
        if (!wait_o && prev_w) begin
          chk(len == cur, "R4 wait length", len, cur);
          chk(req_o && wait_cnt_o == 0, "R4 reissue", req_o, 1);
          chk({addr_o, data_o, sel_o} == held, "R5 reissue same request",
              {addr_o, data_o, sel_o}, held);
        end
        prev_w = wait_o;
      end
    end
  end

  task automatic do_issue(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [SW-1:0] s);
    issue_i = 1'b1; addr_i = a; data_i = d; sel_i = s;
    @(negedge clk);
    issue_i = 1'b0;
    chk(req_o && busy_o, "R2 request raised", {req_o, busy_o}, 2'b11);
    chk(addr_o == a && data_o == d && sel_o == s, "R2 capture", addr_o, a);
  endtask

  // Driver: at a negedge with req_o high, queue the expected draw and send a retry.
  task automatic do_retry(input string tag, input bit poke);
    int g = 0;
    chk(req_o, "R3 request valid before retry", req_o, 1);
    exp_q.push_back(int'(model[4:0]) + 1);
    retry_i = 1'b1;
    @(negedge clk);
    retry_i = 1'b0;
    if (poke && wait_cnt_o >= 2) begin
      ack_i = 1'b1; retry_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0; retry_i = 1'b0;
      chk(busy_o && wait_o, "R10 ack and retry ignored while waiting", {busy_o, wait_o}, 2'b11);
    end
    while (!req_o && g < 40) begin
      @(negedge clk);
      g++;
    end
    chk(req_o, tag, req_o, 1);
  endtask

  task automatic do_ack();
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    chk(!req_o && !busy_o && !wait_o, "R8 ack ends transaction", {req_o, busy_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_o && !busy_o && !wait_o && !err_o && wait_cnt_o == 0, "R1 reset state",
        {req_o, busy_o, wait_o, err_o, wait_cnt_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: capture, then an issue while busy is ignored
    do_issue(32'hA000_0010, 32'h1234_5678, 4'b1010);
    issue_i = 1'b1; addr_i = 32'hDEAD_BEEF; data_i = '1; sel_i = 4'b0101;
    @(negedge clk);
    issue_i = 1'b0;
    chk(addr_o == 32'hA000_0010 && sel_o == 4'b1010, "R2 issue while busy ignored", addr_o, 32'hA000_0010);

    // R8: ack and retry together, ack wins
    ack_i = 1'b1; retry_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0; retry_i = 1'b0;
    chk(!busy_o && !wait_o && !req_o, "R8 ack wins over retry", {busy_o, wait_o}, 0);

    // R10: responses while idle
    ack_i = 1'b1; retry_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0; retry_i = 1'b0;
    chk(!busy_o && !wait_o && !err_o, "R10 responses ignored while idle", {busy_o, wait_o, err_o}, 0);

    // R7 / R9: retry up to the limit, then one more abandons the transaction
    do_issue(32'hB000_0200, 32'hCAFE_0001, 4'b1111);
    do_retry("R4 first reissue", 1'b1);
    do_retry("R7 fresh draw on reissue", 1'b0);
    do_retry("R7 third draw", 1'b0);
    retry_i = 1'b1;
    @(negedge clk);
    retry_i = 1'b0;
    chk(err_o && !busy_o && !wait_o, "R9 give up at limit", {err_o, busy_o, wait_o}, 3'b100);
    @(negedge clk);
    chk(!err_o, "R9 error is one cycle", err_o, 0);

    // Varied patterns: gaps, lanes and retry counts
    for (int t = 0; t < 6; t++) begin
      repeat (t + 1) @(negedge clk);
      do_issue(32'h4000_0000 + t * 32'h44, 32'h0F0F_0000 ^ t, 4'(t + 1));
      do_retry("R4 reissue", t == 2);
      if (t % 2 == 1) do_retry("R7 fresh draw", 1'b0);
      do_ack();
    end

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 every queued draw observed", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule